// File: doc/BRIEF.md
# Parallel NOR Flash Query Identification Sequencer

This block identifies a parallel NOR flash device without any software help, the way a boot controller does just after reset. When `start` is pulsed it drives a simple asynchronous memory bus with a fixed series of command writes and readbacks. Each access is held until the device answers on a ready line. The series puts the device into query mode, checks the three-character signature, and reads the erase-region count. It then copies the identification block into an internal byte file, unlocks the vendor autoselect mode to fetch the manufacturer and device codes, and finally leaves the device in read-array mode.

Every command and query offset is scaled by the number of interleaved devices times the device width in bytes, and is added to the probe base address. When the probe ends, the outputs hold a presence flag, three error flags, the two identity codes, the region count and the primary command-set code. A region selector picks one erase region and returns its block count and block size in bytes, decoded from the little-endian words that were captured.

Top module: `cfi_identify`

## Requirements
- R1: Every bus address equals `base_addr + offset * SCALE`, where SCALE = INTERLEAVE * DEV_BYTES. The command byte is repeated in every byte lane of `bus_wdata`. Only byte lane 0 of `bus_rdata` is used.
- R2: A probe begins with three writes in this order: 0xF0 at offset 0, 0xFF at offset 0, and 0x98 at offset 0x55.
- R3: Offsets 0x10, 0x11 and 0x12 are read in turn and must return 0x51, 0x52 and 0x59. At the first byte that differs, the block writes 0xF0 and then 0xFF at offset 0. It then ends with `present`=0 and all error flags clear.
- R4: The region count is read at offset 0x2C and shown on `region_cnt`. A count of zero leads to the same two reset writes, then the end of the probe with `err_geom`=1 and `present`=0. `present`=1 never occurs together with `region_cnt`=0.
- R5: The identification block is read from consecutive offsets starting at 0x10. It is 29 + 4*min(count, MAX_REGIONS) bytes long. `cmdset_id` is the little-endian pair at offsets 0x13 (low byte) and 0x14 (high byte).
- R6: After the capture, the block writes 0xF0 at offset 0 and only then unlocks autoselect with 0xAA at 0x555, 0x55 at 0x2AA and 0x90 at 0x555. It then reads `mfr_id` at offset 0 and `dev_id` at offset 1.
- R7: A successful probe ends with 0xF0 and then 0xFF at offset 0, followed by `done` with `present`=1.
- R8: Region s (from `region_sel`) starts at capture byte 29+4s. Its little-endian bits 15:0 plus one give `region_blocks`. Its bits 31:16 times 256 give `region_bytes`. If s is not below min(count, MAX_REGIONS), both outputs are zero.
- R9: If `base_addr + 0xFF >= MAP_SIZE`, the start is refused. `err_range` and `done` rise on the next cycle, and no bus access takes place.
- R10: A strobe and its address are held until `bus_rdy` arrives. A ready seen in the last allowed cycle completes the access. After `tmo_lim` strobe cycles with no ready, the strobe drops, `err_timeout` and `done` are set, and no further access follows.
- R11: `busy` is high from the cycle after an accepted start until `done`. A start while busy has no effect on the sequence or on the base address. `done` is a one-cycle pulse.
- R12: `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| base_addr | input | ADDR_W | Probe base address |
| tmo_lim | input | TMO_W | Strobe cycles allowed before timeout |
| region_sel | input | clog2(MAX_REGIONS) | Erase region to decode |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Bus read data |
| bus_rdy | input | 1 | Access complete handshake |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| present | output | 1 | Device identified |
| err_range | output | 1 | Base refused by map limit |
| err_timeout | output | 1 | Ready handshake timed out |
| err_geom | output | 1 | Zero erase regions reported |
| mfr_id | output | 8 | Manufacturer code |
| dev_id | output | 8 | Device code |
| region_cnt | output | 8 | Reported erase-region count |
| cmdset_id | output | 16 | Primary command-set code |
| region_blocks | output | 17 | Blocks in the selected region |
| region_bytes | output | 24 | Block size of the selected region in bytes |

## Verification
The timeout counter and the ready handshake can both resolve in the same cycle. This happens when the device answers in exactly the last strobe cycle that `tmo_lim` allows. The bench sets the responder latency so that ready lands on that cycle and expects a complete probe with no timeout. It then delays the answer by one more cycle and expects `err_timeout`, no `present`, and a quiet bus afterwards. A second start that arrives while the sequence is running is also judged, by checking that the logged bus traffic still uses the first base address and that only one `done` pulse appears.

// File: rtl/cfi_id_pkg.sv
package cfi_id_pkg;

   localparam int HDR_BYTES = 29;

   typedef enum logic [3:0] {
      S_RST_A, S_RST_B, S_QRY_EN, S_SIG_Q, S_SIG_R, S_SIG_Y, S_NREG, S_CAPT,
      S_PRE_AS, S_UNL_1, S_UNL_2, S_AS_EN, S_MFR, S_DEV, S_EXIT_A, S_EXIT_B
   } step_t;

   typedef struct packed {
      logic        is_wr;
      logic [11:0] off;
      logic [7:0]  cmd;
   } op_t;

   // Offset and command of each step; capture walks upward from 0x10.
   function automatic op_t step_op(input step_t s, input logic [7:0] cap);
      op_t o;
      o.is_wr = 1'b1;
      o.off   = 12'h000;
      o.cmd   = 8'h00;
      case (s)
         S_RST_A, S_PRE_AS, S_EXIT_A: o.cmd = 8'hF0;
         S_RST_B, S_EXIT_B:           o.cmd = 8'hFF;
         S_QRY_EN: begin o.off = 12'h055; o.cmd = 8'h98; end
         S_UNL_1:  begin o.off = 12'h555; o.cmd = 8'hAA; end
         S_UNL_2:  begin o.off = 12'h2AA; o.cmd = 8'h55; end
         S_AS_EN:  begin o.off = 12'h555; o.cmd = 8'h90; end
         S_SIG_Q:  begin o.is_wr = 1'b0; o.off = 12'h010; end
         S_SIG_R:  begin o.is_wr = 1'b0; o.off = 12'h011; end
         S_SIG_Y:  begin o.is_wr = 1'b0; o.off = 12'h012; end
         S_NREG:   begin o.is_wr = 1'b0; o.off = 12'h02C; end
         S_CAPT:   begin o.is_wr = 1'b0; o.off = 12'h010 + {4'h0, cap}; end
         S_MFR:    begin o.is_wr = 1'b0; o.off = 12'h000; end
         S_DEV:    begin o.is_wr = 1'b0; o.off = 12'h001; end
         default:  ;
      endcase
      return o;
   endfunction

   function automatic logic [7:0] sig_byte(input step_t s);
      case (s)
         S_SIG_Q: return 8'h51;
         S_SIG_R: return 8'h52;
         default: return 8'h59;
      endcase
   endfunction

endpackage

// File: rtl/cfi_bus_port.sv
module cfi_bus_port #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TMO_W-1:0]  tmo_lim,
   output logic              ack,
   output logic              tmo,
   output logic [7:0]        rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy
);

   logic             active;
   logic             wr_q;
   logic [TMO_W-1:0] wait_cnt;

   assign bus_we = active & wr_q;
   assign bus_re = active & ~wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         wr_q      <= 1'b0;
         wait_cnt  <= '0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         ack       <= 1'b0;
         tmo       <= 1'b0;
         rdata     <= '0;
      end else begin
         ack <= 1'b0;
         tmo <= 1'b0;
         if (!active) begin
            if (req) begin
               active    <= 1'b1;
               wr_q      <= req_wr;
               bus_addr  <= req_addr;
               bus_wdata <= req_wdata;
               wait_cnt  <= '0;
            end
         end else if (bus_rdy) begin
            // ready wins over a timeout falling in the same cycle
            active <= 1'b0;
            ack    <= 1'b1;
            rdata  <= bus_rdata[7:0];
         end else if ({1'b0, wait_cnt} + 1'b1 >= {1'b0, tmo_lim}) begin
            active <= 1'b0;
            tmo    <= 1'b1;
         end else begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfi_id_seq.sv
module cfi_id_seq
   import cfi_id_pkg::*;
#(
   parameter int              ADDR_W      = 24,
   parameter int              SCALE       = 2,
   parameter longint unsigned MAP_SIZE    = 64'h100_0000,
   parameter int              MAX_REGIONS = 4,
   parameter int              IDX_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              launch,
   output logic              req,
   output logic              req_wr,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_cmd,
   input  logic              ack,
   input  logic              tmo,
   input  logic [7:0]        rdata,
   output logic              cap_we,
   output logic [IDX_W-1:0]  cap_idx,
   output logic [7:0]        cap_data,
   output logic              busy,
   output logic              done,
   output logic              present,
   output logic              err_range,
   output logic              err_tmo,
   output logic              err_geom,
   output logic [7:0]        nreg,
   output logic [7:0]        mfr,
   output logic [7:0]        dev
);

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_t;

   st_t               st;
   step_t             step;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  cap_cnt, cap_len;
   logic              abort;
   logic [ADDR_W:0]   last_addr;
   logic              reject;
   logic [7:0]        kept;
   op_t               op;

   assign last_addr = {1'b0, base_addr} + (ADDR_W+1)'(9'h0FF);
   assign reject    = 64'(last_addr) >= MAP_SIZE;
   assign launch    = start && (st == ST_IDLE);
   assign op        = step_op(step, 8'(cap_cnt));
   assign req       = (st == ST_ISSUE);
   assign req_wr    = op.is_wr;
   assign req_cmd   = op.cmd;
   assign req_addr  = base_q + ADDR_W'(op.off) * ADDR_W'(SCALE);
   assign kept      = (rdata > 8'(MAX_REGIONS)) ? 8'(MAX_REGIONS) : rdata;
   assign busy      = (st != ST_IDLE);
   assign cap_we    = (st == ST_WAIT) && ack && (step == S_CAPT);
   assign cap_idx   = cap_cnt;
   assign cap_data  = rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  step <= S_RST_A;  base_q <= '0;
         cap_cnt <= '0;  cap_len <= '0;    abort <= 1'b0;
         done <= 1'b0;   present <= 1'b0;
         err_range <= 1'b0;  err_tmo <= 1'b0;  err_geom <= 1'b0;
         nreg <= '0;  mfr <= '0;  dev <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               present <= 1'b0;  err_range <= 1'b0;  err_tmo <= 1'b0;
               err_geom <= 1'b0; abort <= 1'b0;      nreg <= '0;
               mfr <= '0;  dev <= '0;  cap_cnt <= '0;
               step <= S_RST_A;  base_q <= base_addr;
               if (reject) begin
                  err_range <= 1'b1;
                  done      <= 1'b1;
               end else begin
                  st <= ST_ISSUE;
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: if (tmo) begin
               err_tmo <= 1'b1;
               done    <= 1'b1;
               st      <= ST_IDLE;
            end else if (ack) begin
               st   <= ST_ISSUE;
               step <= step_t'(step + 1'b1);
               case (step)
                  S_SIG_Q, S_SIG_R, S_SIG_Y:
                     if (rdata != sig_byte(step)) begin
                        abort <= 1'b1;
                        step  <= S_EXIT_A;
                     end
                  S_NREG: begin
                     nreg <= rdata;
                     if (rdata == 8'h00) begin
                        abort    <= 1'b1;
                        err_geom <= 1'b1;
                        step     <= S_EXIT_A;
                     end else begin
                        cap_len <= IDX_W'(HDR_BYTES) + IDX_W'({kept, 2'b00});
                     end
                  end
                  S_CAPT: begin
                     cap_cnt <= cap_cnt + 1'b1;
                     if (cap_cnt + 1'b1 != cap_len) step <= S_CAPT;
                  end
                  S_MFR: mfr <= rdata;
                  S_DEV: dev <= rdata;
                  S_EXIT_B: begin
                     st      <= ST_IDLE;
                     done    <= 1'b1;
                     present <= !abort;
                  end
                  default: ;
               endcase
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfi_ident_store.sv
module cfi_ident_store
   import cfi_id_pkg::*;
#(
   parameter int MAX_REGIONS = 4,
   parameter int CAP_MAX     = 45,
   parameter int IDX_W       = 6,
   parameter int RSEL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [7:0]        wdata,
   input  logic [7:0]        nreg,
   input  logic [RSEL_W-1:0] region_sel,
   output logic [15:0]       cmdset_id,
   output logic [16:0]       region_blocks,
   output logic [23:0]       region_bytes
);

   logic [7:0] mem [CAP_MAX];
   int         stored_n;
   int         b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CAP_MAX; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < CAP_MAX; i++) mem[i] <= '0;
      end else if (we && int'(widx) < CAP_MAX) begin
         mem[widx] <= wdata;
      end
   end

   assign stored_n  = (int'(nreg) > MAX_REGIONS) ? MAX_REGIONS : int'(nreg);
   assign b         = HDR_BYTES + 4 * int'(region_sel);
   assign cmdset_id = {mem[4], mem[3]};

   always_comb begin
      region_blocks = '0;
      region_bytes  = '0;
      if (int'(region_sel) < stored_n) begin
         region_blocks = {1'b0, mem[b+1], mem[b]} + 17'd1;
         region_bytes  = {mem[b+3], mem[b+2], 8'h00};
      end
   end

endmodule

// File: rtl/cfi_identify.sv
module cfi_identify
   import cfi_id_pkg::*;
#(
   parameter int              ADDR_W      = 24,
   parameter int              DATA_W      = 16,
   parameter int              INTERLEAVE  = 1,
   parameter int              DEV_BYTES   = 2,
   parameter int              MAX_REGIONS = 4,
   parameter longint unsigned MAP_SIZE    = 64'h100_0000,
   parameter int              TMO_W       = 16,
   localparam int             RSEL_W      = $clog2(MAX_REGIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [TMO_W-1:0]  tmo_lim,
   input  logic [RSEL_W-1:0] region_sel,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy,
   output logic              busy,
   output logic              done,
   output logic              present,
   output logic              err_range,
   output logic              err_timeout,
   output logic              err_geom,
   output logic [7:0]        mfr_id,
   output logic [7:0]        dev_id,
   output logic [7:0]        region_cnt,
   output logic [15:0]       cmdset_id,
   output logic [16:0]       region_blocks,
   output logic [23:0]       region_bytes
);

   localparam int SCALE   = INTERLEAVE * DEV_BYTES;
   localparam int LANES   = DATA_W / 8;
   localparam int CAP_MAX = HDR_BYTES + 4 * MAX_REGIONS;
   localparam int IDX_W   = $clog2(CAP_MAX + 1);

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_chk_dw
      $error("DATA_W must be a whole number of bytes");
   end
   if (MAX_REGIONS < 2 || MAX_REGIONS > 32) begin : g_chk_reg
      $error("MAX_REGIONS must lie in 2..32");
   end
   if (SCALE < 1 || ADDR_W < 12) begin : g_chk_scale
      $error("SCALE must be positive and ADDR_W at least 12");
   end

   logic              launch, req, req_wr, ack, tmo, cap_we;
   logic [ADDR_W-1:0] req_addr;
   logic [7:0]        req_cmd, rdata, cap_data;
   logic [IDX_W-1:0]  cap_idx;
   logic [DATA_W-1:0] cmd_word;

   if (DATA_W == 8) begin : g_narrow
      assign cmd_word = req_cmd;
   end else begin : g_wide
      assign cmd_word = {LANES{req_cmd}};
   end

   cfi_id_seq #(
      .ADDR_W(ADDR_W), .SCALE(SCALE), .MAP_SIZE(MAP_SIZE),
      .MAX_REGIONS(MAX_REGIONS), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .launch(launch), .req(req), .req_wr(req_wr), .req_addr(req_addr),
      .req_cmd(req_cmd), .ack(ack), .tmo(tmo), .rdata(rdata),
      .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
      .busy(busy), .done(done), .present(present), .err_range(err_range),
      .err_tmo(err_timeout), .err_geom(err_geom), .nreg(region_cnt),
      .mfr(mfr_id), .dev(dev_id)
   );

   cfi_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_port (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(cmd_word), .tmo_lim(tmo_lim),
      .ack(ack), .tmo(tmo), .rdata(rdata), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
   );

   cfi_ident_store #(
      .MAX_REGIONS(MAX_REGIONS), .CAP_MAX(CAP_MAX), .IDX_W(IDX_W), .RSEL_W(RSEL_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clr(launch), .we(cap_we), .widx(cap_idx),
      .wdata(cap_data), .nreg(region_cnt), .region_sel(region_sel),
      .cmdset_id(cmdset_id), .region_blocks(region_blocks),
      .region_bytes(region_bytes)
   );

endmodule

// File: rtl/cfi_identify_chk.sv
module cfi_identify_chk #(
   parameter int ADDR_W = 24,
   parameter int TMO_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              bus_we,
   input logic              bus_re,
   input logic              bus_rdy,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              err_range,
   input logic              present,
   input logic [7:0]        region_cnt,
   input logic [TMO_W-1:0]  tmo_lim
);

   logic [TMO_W:0] stall_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          stall_cnt <= '0;
      else if ((bus_we || bus_re) && !bus_rdy) stall_cnt <= stall_cnt + 1'b1;
      else                                 stall_cnt <= '0;
   end

   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_we || bus_re) && !bus_rdy) |=> (!(bus_we || bus_re) || $stable(bus_addr)));

   p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stall_cnt <= {1'b0, tmo_lim});

   p_range_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_range |-> !(bus_we || bus_re));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_present_regions_r4: assert property (@(posedge clk) disable iff (!rst_n)
      present |-> region_cnt != 8'h00);

endmodule

bind cfi_identify cfi_identify_chk #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/cfi_identify_test.sv
module cfi_identify_test;

   localparam int AW = 16, DW = 16, SC = 2, MAXR = 4, TW = 8;

   logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [TW-1:0] tmo_lim = 8'd64;
   logic [1:0]    region_sel = '0;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          bus_we, bus_re, bus_rdy;
   logic          busy, done, present, err_range, err_timeout, err_geom;
   logic [7:0]    mfr_id, dev_id, region_cnt;
   logic [15:0]   cmdset_id;
   logic [16:0]   region_blocks;
   logic [23:0]   region_bytes;

   cfi_identify #(.ADDR_W(AW), .DATA_W(DW), .INTERLEAVE(1), .DEV_BYTES(2),
                  .MAX_REGIONS(MAXR), .MAP_SIZE(64'h4000), .TMO_W(TW)) uut (.*);

   always #5 clk = ~clk;

   int total = 0, fails = 0, done_cnt = 0;

   // behavioural device
   logic [7:0]  qtab [64];
   logic [7:0]  dev_mfr, dev_code;
   logic [AW-1:0] base_cur = '0;
   bit          capable = 1'b1, stall = 1'b0;
   int          lat = 0, wcnt = 0, mode = 0, unl = 0, nested_bad = 0;
   int          log_n = 0, exp_n = 0;
   bit          log_wr [128], exp_wr [128];
   logic [AW-1:0] log_addr [128], exp_addr [128];
   logic [DW-1:0] log_data [128], exp_data [128];

   function automatic logic [7:0] dev_val(input int off);
      if (mode == 1) return (off >= 'h10 && off < 'h50) ? qtab[off-'h10] : 8'h00;
      if (mode == 2) return (off == 0) ? dev_mfr : (off == 1) ? dev_code : 8'h00;
      return 8'(off) ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (done) done_cnt <= done_cnt + 1;
      if (!rst_n) begin
         bus_rdy <= 1'b0; bus_rdata <= '0; wcnt = 0;
      end else begin
         bus_rdy <= 1'b0;
         if ((bus_we || bus_re) && !bus_rdy && !stall) begin
            if (wcnt < lat) wcnt = wcnt + 1;
            else begin
               int off;
               wcnt = 0;
               off = (int'(bus_addr) - int'(base_cur)) / SC;
               bus_rdy <= 1'b1;
               if (log_n < 128) begin
                  log_wr[log_n] = bus_we; log_addr[log_n] = bus_addr;
                  log_data[log_n] = bus_we ? bus_wdata : '0; log_n = log_n + 1;
               end
               if (bus_we) begin
                  case (bus_wdata[7:0])
                     8'hF0, 8'hFF: begin mode = 0; unl = 0; end
                     8'h98: if (off == 'h55 && capable) mode = 1;
                     8'hAA: if (off == 'h555) begin if (mode == 1) nested_bad++; unl = 1; end
                     8'h55: if (off == 'h2AA && unl == 1) unl = 2;
                     8'h90: if (off == 'h555 && unl == 2) begin mode = 2; unl = 0; end
                     default: ;
                  endcase
               end else begin
                  bus_rdata <= {2{dev_val(off)}};
               end
            end
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void push(input bit wr, input int off, input logic [7:0] cmd);
      exp_wr[exp_n]   = wr;
      exp_addr[exp_n] = base_cur + AW'(off * SC);
      exp_data[exp_n] = wr ? {cmd, cmd} : '0;
      exp_n++;
   endfunction

   // expected bus trace from R2..R7
   function automatic void build_exp();
      logic [7:0] sig [3];
      int n, len;
      bit ok;
      sig[0] = 8'h51; sig[1] = 8'h52; sig[2] = 8'h59;
      exp_n = 0; ok = 1'b1;
      push(1, 0, 8'hF0); push(1, 0, 8'hFF); push(1, 'h55, 8'h98);
      for (int i = 0; i < 3 && ok; i++) begin
         logic [7:0] v;
         push(0, 'h10 + i, 8'h00);
         v = capable ? qtab[i] : (8'('h10 + i) ^ 8'h5A);
         if (v != sig[i]) ok = 1'b0;
      end
      if (ok) begin
         push(0, 'h2C, 8'h00);
         n = int'(qtab[28]);
         if (n != 0) begin
            len = 29 + 4 * ((n > MAXR) ? MAXR : n);
            for (int i = 0; i < len; i++) push(0, 'h10 + i, 8'h00);
            push(1, 0, 8'hF0); push(1, 'h555, 8'hAA); push(1, 'h2AA, 8'h55);
            push(1, 'h555, 8'h90); push(0, 0, 8'h00); push(0, 1, 8'h00);
         end
      end
      push(1, 0, 8'hF0); push(1, 0, 8'hFF);
   endfunction

   function automatic void fill_table(input int n);
      for (int i = 0; i < 64; i++) qtab[i] = 8'($urandom);
      qtab[0] = 8'h51; qtab[1] = 8'h52; qtab[2] = 8'h59;
      qtab[28] = 8'(n);
      dev_mfr = 8'($urandom); dev_code = 8'($urandom);
   endfunction

   task automatic run_probe(input logic [AW-1:0] b);
      int d0;
      base_cur = b; log_n = 0; wcnt = 0; d0 = done_cnt;
      @(negedge clk); base_addr = b; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 4000 && done_cnt == d0; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_trace(input string req);
      int bad = -1;
      build_exp();
      chk({req, " trace length"}, log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
         if (bad < 0 && (log_wr[i] !== exp_wr[i] || log_addr[i] !== exp_addr[i] ||
                         log_data[i] !== exp_data[i])) bad = i;
      if (bad >= 0) chk({req, " trace access"}, {log_addr[bad], log_data[bad]},
                        {exp_addr[bad], exp_data[bad]});
      else chk({req, " trace access"}, 0, 0);
   endtask

   task automatic check_ok(input string tag);
      int n, st;
      n = int'(qtab[28]); st = (n > MAXR) ? MAXR : n;
      check_trace({tag, " R1 R2 R5 R6"});
      chk({tag, " R7 present"}, present, 1);
      chk({tag, " R7 errors"}, {err_range, err_timeout, err_geom}, 0);
      chk({tag, " R6 mfr"}, mfr_id, dev_mfr);
      chk({tag, " R6 dev"}, dev_id, dev_code);
      chk({tag, " R4 count"}, region_cnt, n);
      chk({tag, " R5 cmdset"}, cmdset_id, {qtab[4], qtab[3]});
      chk({tag, " R7 read mode"}, mode, 0);
      chk({tag, " R6 nesting"}, nested_bad, 0);
      for (int s = 0; s < MAXR; s++) begin
         int b = 29 + 4 * s;
         logic [16:0] eb; logic [23:0] ez;
         eb = (s < st) ? {1'b0, qtab[b+1], qtab[b]} + 17'd1 : '0;
         ez = (s < st) ? {qtab[b+3], qtab[b+2], 8'h00} : '0;
         region_sel = 2'(s); #1;
         chk({tag, " R8 blocks"}, region_blocks, eb);
         chk({tag, " R8 bytes"}, region_bytes, ez);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7341));
      fill_table(2);
      repeat (3) @(negedge clk);
      chk("R11 reset busy", busy, 0);
      chk("R12 reset strobes", {bus_we, bus_re}, 0);
      chk("R7 reset status", {done, present, err_range, err_timeout, err_geom}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // random identifications
      for (int it = 0; it < 8; it++) begin
         fill_table($urandom_range(1, 6));
         lat = $urandom_range(0, 3);
         run_probe(AW'($urandom_range(0, 'h1800)) & 16'hFFFE);
         check_ok($sformatf("rand%0d", it));
      end

      // directed: region count above storage
      fill_table(9); lat = 1;
      run_probe(16'h0200);
      check_ok("many regions R5");

      // R3: signature mismatch on the second character
      fill_table(3); qtab[1] = 8'h00;
      run_probe(16'h0400);
      check_trace("R3 bad sig");
      chk("R3 not present", present, 0);
      chk("R3 no errors", {err_range, err_timeout, err_geom}, 0);
      chk("R3 read mode", mode, 0);

      // R3: device without query support
      capable = 1'b0; fill_table(2);
      run_probe(16'h0600);
      check_trace("R3 absent");
      chk("R3 absent present", present, 0);
      capable = 1'b1;

      // R4: zero regions
      fill_table(0);
      run_probe(16'h0800);
      check_trace("R4 zero regions");
      chk("R4 geom error", err_geom, 1);
      chk("R4 present", present, 0);
      region_sel = 2'd0; #1;
      chk("R8 empty decode", region_blocks, 0);

      // R9: range boundary
      fill_table(1); lat = 0;
      run_probe(16'h3F00);
      chk("R9 last legal base", present, 1);
      run_probe(16'h3F01);
      chk("R9 refused", err_range, 1);
      chk("R9 no bus access", log_n, 0);
      chk("R9 present", present, 0);

      // R10: ready in the last allowed cycle, then one cycle too late
      tmo_lim = 8'd6; fill_table(2); lat = 4;
      run_probe(16'h1000);
      chk("R10 ready at limit", {present, err_timeout}, 2'b10);
      lat = 5;
      run_probe(16'h1000);
      chk("R10 timeout flag", err_timeout, 1);
      chk("R10 timeout present", present, 0);
      stall = 1'b1;
      run_probe(16'h1200);
      chk("R10 stall timeout", err_timeout, 1);
      repeat (20) @(negedge clk);
      chk("R10 bus quiet", {bus_we, bus_re}, 0);
      chk("R10 no access", log_n, 0);
      stall = 1'b0; tmo_lim = 8'd64;

      // R11: start while busy is ignored
      begin
         int d0;
         fill_table(3); lat = 2; base_cur = 16'h1400; log_n = 0; wcnt = 0; d0 = done_cnt;
         @(negedge clk); base_addr = 16'h1400; start = 1'b1;
         @(negedge clk); start = 1'b0;
         chk("R11 busy after start", busy, 1);
         repeat (10) @(negedge clk);
         base_addr = 16'h2000; start = 1'b1;
         @(negedge clk); start = 1'b0;
         for (int k = 0; k < 4000 && done_cnt == d0; k++) @(negedge clk);
         repeat (10) @(negedge clk);
         chk("R11 single done", done_cnt - d0, 1);
         chk("R11 idle", busy, 0);
         check_ok("R11 restart ignored");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

endmodule